// File: doc/BRIEF.md
# OTP Read Access Controller

This block sits between a register bus and a one-time-programmable word array whose contents reach it in parallel. Software opens the read banks with a control write. While they are open, any word can be read, and the data returns one clock later, as it would from an ordinary register. A word that falls in a read-locked region is never returned. The read gives a fixed poison pattern in its place and raises an error flag. That flag stays set until software clears it, and reads of other words keep working in the meantime.

The lock bits live in one designated word of the array. The block collects them into a register that can only ever gain bits. A separate reload request copies a small window of array words into shadow registers. The copy holds a busy flag for a fixed number of cycles and never opens the banks.

Top module: `otp_rd_ctrl`

## Requirements
- R1: After reset, bank_open_o, err_o, busy_o, rd_valid_o, rd_data_o and shadow_o are all zero.
- R2: A control write sets bank_open_o to bit 0 of ctl_wdata_i. Nothing else changes it, and a reload request leaves it unchanged.
- R3: With the banks open and busy_o low, a read of word `a` returns word `a` of fuse_i on rd_data_o, with rd_valid_o high, one cycle after rd_en_i.
- R4: A read of a word in a locked region returns 32'hBADA_BADA and sets err_o.
- R5: err_o stays set until a control write with bit 1 of ctl_wdata_i high clears it. When a locked read and a clear fall in the same cycle, the read wins and err_o is set.
- R6: While err_o is set, reads of unlocked words still return the stored data.
- R7: A read issued while the banks are closed or busy_o is high returns zero and leaves err_o unchanged.
- R8: A control write with bit 2 high, issued while busy_o is low, holds busy_o high for RELOAD_CYCLES cycles. When busy_o drops, shadow_o holds words SHADOW_BASE upward of fuse_i, with the lowest word in the lowest 32 bits. A reload request made while busy_o is high is ignored.
- R9: Bit r of word LOCK_WORD of fuse_i locks region r, which covers words r*NUM_WORDS/NUM_REGIONS up to (r+1)*NUM_WORDS/NUM_REGIONS-1. A lock bit, once seen, stays in force even if the array word later reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control data: bit 0 bank open, bit 1 error clear, bit 2 reload request |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW | Word address of the read |
| fuse_i | input | NUM_WORDS*32 | Parallel-loaded array contents, word i at bits 32*i upward |
| rd_data_o | output | 32 | Read data, registered |
| rd_valid_o | output | 1 | High one cycle after rd_en_i |
| bank_open_o | output | 1 | Banks open for reading |
| busy_o | output | 1 | Shadow reload in progress |
| err_o | output | 1 | Sticky locked-read error flag |
| shadow_o | output | NUM_SHADOW*32 | Shadow registers |

## Verification
The bench builds the block with 16 words in 4 regions of 4 words each. The lock word is word 15, so the lock word sits inside an unlocked region of its own. Reload copies 2 words starting at word 2 and takes 4 cycles. These values keep every busy window short enough to count edge by edge, including a reload request made while busy and a read landing in the middle of a reload. The narrow regions put locked and unlocked words next to each other, so the region boundary can be tested. The bench also rewrites the lock word in the array model, both clearing bits and adding them, to show that lock bits can be gained and never lost.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;
  localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;

  typedef struct packed {
    logic reload;
    logic err_clr;
    logic bank_open;
  } ctl_t;
endpackage

// File: rtl/otp_lock_bank.sv
module otp_lock_bank #(
  parameter int NUM_WORDS   = 16,
  parameter int NUM_REGIONS = 4,
  parameter int AW          = $clog2(NUM_WORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_REGIONS-1:0] lock_word_i,
  input  logic [AW-1:0]          addr_i,
  output logic                   locked_o
);
  localparam int WPR = NUM_WORDS / NUM_REGIONS;

  logic [NUM_REGIONS-1:0] lock_q;
  logic [NUM_REGIONS-1:0] hit;

  // lock bits only accumulate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else         lock_q <= lock_q | lock_word_i;
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam int LO = r * WPR;
    localparam int HI = (r + 1) * WPR;
    assign hit[r] = lock_q[r] && (int'(addr_i) >= LO) && (int'(addr_i) < HI);
  end

  assign locked_o = |hit;

  // R9
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_q) & ~lock_q) == '0);
endmodule

// File: rtl/otp_shadow_loader.sv
module otp_shadow_loader #(
  parameter int NUM_WORDS     = 16,
  parameter int NUM_SHADOW    = 2,
  parameter int SHADOW_BASE   = 2,
  parameter int RELOAD_CYCLES = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [NUM_WORDS*32-1:0]   fuse_i,
  output logic                      busy_o,
  output logic [NUM_SHADOW*32-1:0]  shadow_o
);
  localparam int CW = $clog2(RELOAD_CYCLES + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(RELOAD_CYCLES - 1);
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_SHADOW; s++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   shadow_o[32*s +: 32] <= '0;
      else if (done) shadow_o[32*s +: 32] <= fuse_i[32*(SHADOW_BASE+s) +: 32];
    end
  end

  assign busy_o = busy_q;

  // R8
  reload_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(shadow_o));
endmodule

// File: rtl/otp_rd_ctrl.sv
module otp_rd_ctrl
  import otp_rd_pkg::*;
#(
  parameter int NUM_WORDS     = 16,
  parameter int NUM_REGIONS   = 4,
  parameter int LOCK_WORD     = NUM_WORDS - 1,
  parameter int NUM_SHADOW    = 2,
  parameter int SHADOW_BASE   = 2,
  parameter int RELOAD_CYCLES = 4,
  parameter int AW            = $clog2(NUM_WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ctl_wr_i,
  input  logic [2:0]                ctl_wdata_i,
  input  logic                      rd_en_i,
  input  logic [AW-1:0]             rd_addr_i,
  input  logic [NUM_WORDS*32-1:0]   fuse_i,
  output logic [31:0]               rd_data_o,
  output logic                      rd_valid_o,
  output logic                      bank_open_o,
  output logic                      busy_o,
  output logic                      err_o,
  output logic [NUM_SHADOW*32-1:0]  shadow_o
);
  ctl_t        ctl;
  logic        bank_open_q, err_q, rd_valid_q;
  logic [31:0] rd_data_q, rd_data_d, word;
  logic        busy, lock_hit, rd_ok;

  assign ctl = ctl_t'(ctl_wdata_i);

  otp_lock_bank #(
    .NUM_WORDS(NUM_WORDS), .NUM_REGIONS(NUM_REGIONS), .AW(AW)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_word_i(fuse_i[32*LOCK_WORD +: NUM_REGIONS]),
    .addr_i     (rd_addr_i),
    .locked_o   (lock_hit)
  );

  otp_shadow_loader #(
    .NUM_WORDS(NUM_WORDS), .NUM_SHADOW(NUM_SHADOW),
    .SHADOW_BASE(SHADOW_BASE), .RELOAD_CYCLES(RELOAD_CYCLES)
  ) u_reload (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ctl_wr_i && ctl.reload),
    .fuse_i  (fuse_i),
    .busy_o  (busy),
    .shadow_o(shadow_o)
  );

  assign rd_ok = rd_en_i && bank_open_q && !busy;

  always_comb begin
    word = '0;
    if (int'(rd_addr_i) < NUM_WORDS) word = fuse_i[32*int'(rd_addr_i) +: 32];
    if (!rd_ok)        rd_data_d = '0;
    else if (lock_hit) rd_data_d = POISON_WORD;
    else               rd_data_d = word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_open_q <= 1'b0;
      err_q       <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
    end else begin
      if (ctl_wr_i) bank_open_q <= ctl.bank_open;
      // a locked read wins over a same-cycle clear
      if (rd_ok && lock_hit)           err_q <= 1'b1;
      else if (ctl_wr_i && ctl.err_clr) err_q <= 1'b0;
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= rd_data_d;
    end
  end

  assign rd_data_o   = rd_data_q;
  assign rd_valid_o  = rd_valid_q;
  assign bank_open_o = bank_open_q;
  assign busy_o      = busy;
  assign err_o       = err_q;

  // R2
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i |=> $stable(bank_open_o));
  // R4
  poison_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && bank_open_o && !busy_o && lock_hit) |=> (rd_data_o == POISON_WORD) && err_o);
  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !ctl_wr_i) |=> err_o);
  // R7
  closed_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (!bank_open_o || busy_o) && !ctl_wr_i) |=> (rd_data_o == '0) && $stable(err_o));
endmodule

// File: tb/tb_otp_rd_ctrl.sv
module tb_otp_rd_ctrl;
  localparam int NW = 16, NR = 4, LW = 15, NS = 2, SB = 2, RC = 4, AW = 4;
  localparam logic [31:0] POISON = 32'hBADA_BADA;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, rd_en = 0;
  logic [2:0] ctl_wdata = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [NW*32-1:0] fuse;
  logic [31:0] rd_data;
  logic rd_valid, bank_open, busy, err;
  logic [NS*32-1:0] shadow;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  otp_rd_ctrl #(
    .NUM_WORDS(NW), .NUM_REGIONS(NR), .LOCK_WORD(LW),
    .NUM_SHADOW(NS), .SHADOW_BASE(SB), .RELOAD_CYCLES(RC), .AW(AW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .fuse_i(fuse), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .bank_open_o(bank_open), .busy_o(busy), .err_o(err),
    .shadow_o(shadow)
  );

  function automatic logic [31:0] fw(int i);
    return fuse[32*i +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl(logic open, logic clr, logic rl);
    @(negedge clk);
    ctl_wr = 1; ctl_wdata = {rl, clr, open};
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; ctl_wdata = '0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    rd_en = 1; rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 bank_open", 32'(bank_open), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 shadow", shadow[31:0] | shadow[63:32], 0);
  endtask

  task automatic t_closed_read;
    rd(3);
    chk("R7 closed data", rd_data, 0);
    chk("R7 closed valid", 32'(rd_valid), 1);
    chk("R7 closed err", 32'(err), 0);
  endtask

  task automatic t_open_read;
    ctl(1, 0, 0);
    chk("R2 open", 32'(bank_open), 1);
    rd(0);  chk("R3 word0", rd_data, fw(0));
    rd(5);  chk("R3 word5", rd_data, fw(5));
    rd(15); chk("R3 word15", rd_data, fw(15));
    rd(7);  chk("R9 boundary word7 unlocked", rd_data, fw(7));
  endtask

  task automatic t_locked;
    rd(8);  chk("R4 poison word8", rd_data, POISON);
    chk("R4 err set", 32'(err), 1);
    rd(4);  chk("R6 word4 after error", rd_data, fw(4));
    chk("R5 err held", 32'(err), 1);
    rd(11); chk("R4 poison word11", rd_data, POISON);
  endtask

  task automatic t_err_clear;
    ctl(1, 1, 0);
    chk("R5 err cleared", 32'(err), 0);
    chk("R2 still open", 32'(bank_open), 1);
    @(negedge clk);
    ctl_wr = 1; ctl_wdata = 3'b011; rd_en = 1; rd_addr = AW'(9);
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; ctl_wdata = '0; rd_en = 0;
    chk("R5 set wins over clear", 32'(err), 1);
    chk("R4 poison word9", rd_data, POISON);
    ctl(1, 1, 0);
  endtask

  task automatic t_lock_sticky;
    fuse[32*LW +: 32] = 32'h0;
    repeat (2) @(negedge clk);
    rd(10); chk("R9 lock kept after clear", rd_data, POISON);
    fuse[32*LW +: 32] = 32'h1;
    repeat (2) @(negedge clk);
    rd(1);  chk("R9 new lock region0", rd_data, POISON);
    rd(12); chk("R9 region3 unlocked", rd_data, fw(12));
    ctl(1, 1, 0);
  endtask

  task automatic t_reload_closed;
    ctl(0, 0, 0);
    ctl(0, 0, 1);
    chk("R8 busy high", 32'(busy), 1);
    repeat (RC) @(negedge clk);
    chk("R8 busy low", 32'(busy), 0);
    chk("R2 reload keeps closed", 32'(bank_open), 0);
    chk("R8 shadow0", shadow[31:0], fw(SB));
    chk("R8 shadow1", shadow[63:32], fw(SB + 1));
  endtask

  task automatic t_reload_open;
    fuse[32*SB +: 32] = 32'h5A5A_0102;
    ctl(1, 0, 1);
    chk("R8 busy start", 32'(busy), 1);
    ctl_wr = 1; ctl_wdata = 3'b101; rd_en = 1; rd_addr = AW'(5);
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; ctl_wdata = '0; rd_en = 0;
    chk("R7 busy read zero", rd_data, 0);
    chk("R7 busy read err", 32'(err), 0);
    repeat (RC - 2) @(negedge clk);
    chk("R8 busy last cycle", 32'(busy), 1);
    chk("R8 shadow unchanged", shadow[31:0], 32'hC0DE_0002);
    @(negedge clk);
    chk("R8 busy ends on time", 32'(busy), 0);
    chk("R8 shadow reloaded", shadow[31:0], 32'h5A5A_0102);
    rd(6); chk("R3 read after reload", rd_data, fw(6));
  endtask

  initial begin
    for (int i = 0; i < NW; i++) fuse[32*i +: 32] = 32'hC0DE_0000 | 32'(i);
    fuse[32*LW +: 32] = 32'h0000_0004; // region 2 locked
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_closed_read();
    t_open_read();
    t_locked();
    t_err_clear();
    t_lock_sticky();
    t_reload_closed();
    t_reload_open();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule